// File: doc/BRIEF.md
# Dual Down-Counting Timer with Shared Interrupt

This block holds two identical periodic down-counters behind a 32-bit register interface. Each channel has a reload value, a live count that software can read, and a control word. The control word picks what the channel does (copy the reload value into the counter, freeze, or count) and which of several tick-enable inputs advances it. When a counting channel expires, it reloads from its reload value and raises its own bit in a shared raw status register.

Both channels feed one interrupt unit. It has a mask register and a masked status view, and software clears raw bits by writing ones to the acknowledge address. The single level interrupt output is high while any masked status bit is set. The tick enables are one-cycle strobes from outside the block: four rate strobes plus one external strobe. The block does not derive clock frequencies itself.

Top module: `dual_down_timer`

## Requirements
- R1: While reset is asserted and just after it, both channels are stopped, counts and reload values read 0, and raw status, mask and the irq output are 0.
- R2: Reload values are read back at their own address: channel 0 at 0x00 and channel 1 at 0x10. Reads of unmapped addresses return 0. Writes to the count addresses (0x04, 0x14), the status addresses (0x50, 0x54) or unmapped addresses change nothing.
- R3: Writing a control word whose bits [1:0] equal 0 (at 0x08 for channel 0, 0x18 for channel 1) copies that channel's reload value into its count on the next cycle. The channel then stays stopped.
- R4: With control bits [1:0] = 2, each selected tick lowers the count by one. With bits [1:0] = 1 or 3, the count stays frozen whatever ticks arrive.
- R5: A selected tick that arrives while a counting channel's count is 0 or 1 reloads the count from the reload value and sets the channel's raw status bit: bit 0 for channel 0, bit 1 for channel 1. Raw status is read at 0x50.
- R6: Control bits [4:2] select the tick. Codes 4, 5, 6 and 7 use rate_tick[0], [1], [2] and [3]. Codes 0 and 1 use ext_tick. Codes 2 and 3 select no tick at all.
- R7: The masked status at 0x54 is the raw status ANDed with the mask. irq is high exactly when the masked status is nonzero.
- R8: Writing 0x4C clears each raw bit written as 1 and leaves bits written as 0 unchanged. An expiry in the same cycle as an acknowledge of its bit leaves the bit set.
- R9: The mask at 0x48 (bits [1:0]) is read back and takes effect on irq on the cycle after the write. Writing it does not change the raw status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register interface |
| addr | input | ADDR_W | Byte address of the 32-bit register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| rate_tick | input | 4 | Four rate tick-enable strobes |
| ext_tick | input | 1 | External tick-enable strobe |
| irq | output | 1 | Level interrupt, OR of the masked status bits |

## Verification
The bench strobes sources that are not selected, including codes 2 and 3. A design with a wrong source decode would then count on a stray strobe and show a count lower than expected. It ticks a channel that is holding in control code 1 and in the illegal code 3: a design that treats 3 as run would show the count move. The bench drives an expiry and an acknowledge of the same bit in one cycle. A design that lets the clear win would drop that event and read raw status 0 instead of 2. The bench also walks the count down to expiry and checks the reload, the status bit position for each channel, and irq under a changing mask. An off-by-one in the expiry point, swapped status bits or an unmasked interrupt each show up as a wrong count, a wrong status word or a wrong irq level.

// File: rtl/dual_down_timer.sv
module dual_down_timer #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [3:0]        rate_tick,
  input  logic              ext_tick,
  output logic              irq
);

  localparam int NCH    = 2;
  localparam int STRIDE = 16;
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(8'h48);
  localparam logic [ADDR_W-1:0] ACK_A  = ADDR_W'(8'h4C);
  localparam logic [ADDR_W-1:0] RAW_A  = ADDR_W'(8'h50);
  localparam logic [ADDR_W-1:0] MSKD_A = ADDR_W'(8'h54);
  localparam logic [1:0] OP_LOAD = 2'd0;
  localparam logic [1:0] OP_RUN  = 2'd2;

  logic [NCH-1:0][CNT_W-1:0] div_q;
  logic [NCH-1:0][CNT_W-1:0] cnt_q;
  logic [NCH-1:0][4:0]       ctl_q;
  logic [NCH-1:0]            expire;
  logic [NCH-1:0]            raw_q;
  logic [NCH-1:0]            mask_q;

  wire ack_wr  = wr_en && addr == ACK_A;
  wire mask_wr = wr_en && addr == MASK_A;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] DIV_A = ADDR_W'(ch * STRIDE);
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(ch * STRIDE + 8);

    wire div_wr = wr_en && addr == DIV_A;
    wire ctl_wr = wr_en && addr == CTL_A;
    wire run    = ctl_q[ch][1:0] == OP_RUN;
    logic tick;

    always_comb begin
      case (ctl_q[ch][4:2])
        3'd0, 3'd1: tick = ext_tick;
        3'd4, 3'd5, 3'd6, 3'd7: tick = rate_tick[ctl_q[ch][3:2]];
        default: tick = 1'b0;
      endcase
    end

    assign expire[ch] = run && tick && !ctl_wr && cnt_q[ch] <= CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        div_q[ch] <= '0;
        cnt_q[ch] <= '0;
        ctl_q[ch] <= '0;
      end else begin
        if (div_wr) div_q[ch] <= wdata[CNT_W-1:0];
        if (ctl_wr) begin
          ctl_q[ch] <= wdata[4:0];
          if (wdata[1:0] == OP_LOAD) cnt_q[ch] <= div_q[ch];
        end else if (run && tick) begin
          cnt_q[ch] <= expire[ch] ? div_q[ch] : cnt_q[ch] - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~(ack_wr ? wdata[NCH-1:0] : '0)) | expire;
      if (mask_wr) mask_q <= wdata[NCH-1:0];
    end
  end

  assign irq = |(raw_q & mask_q);

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADDR_W'(c * STRIDE))     rdata = 32'(div_q[c]);
      if (addr == ADDR_W'(c * STRIDE + 4)) rdata = 32'(cnt_q[c]);
      if (addr == ADDR_W'(c * STRIDE + 8)) rdata = 32'(ctl_q[c]);
    end
    if (addr == MASK_A) rdata = 32'(mask_q);
    if (addr == RAW_A)  rdata = 32'(raw_q);
    if (addr == MSKD_A) rdata = 32'(raw_q & mask_q);
  end

endmodule

module dual_down_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [31:0]           wdata,
  input logic                  irq,
  input logic [1:0]            raw_q,
  input logic [1:0][CNT_W-1:0] cnt_q,
  input logic [1:0][CNT_W-1:0] div_q,
  input logic [1:0][4:0]       ctl_q,
  input logic [1:0]            expire
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !irq && raw_q == 2'b00);

  // R3
  load_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h08) && wdata[1:0] == 2'd0) |=> cnt_q[0] == $past(div_q[0]));

  // R4
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0][1:0] != 2'd2 && !(wr_en && addr == ADDR_W'(8'h08))) |=> $stable(cnt_q[0]));

  // R5
  expiry_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire[1] |=> raw_q[1]);

  // R7
  mask_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h48) && wdata[1:0] == 2'b00) |=> !irq);

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h4C) && wdata[0] && !expire[0]) |=> !raw_q[0]);

endmodule

bind dual_down_timer dual_down_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/dual_down_timer_test.sv
module dual_down_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  rate_tick = '0;
  logic        ext_tick = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  dual_down_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rate_tick(rate_tick), .ext_tick(ext_tick), .irq(irq)
  );

  always #10 clk = ~clk;

  always begin
    @(negedge clk);
    #2;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_irq ? 32'(irq) : rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual %0h expected %0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = a;
    q.push_back('{1'b0, e, tag});
    #4;
  endtask

  task automatic expect_irq(input bit e, input string tag);
    @(negedge clk);
    q.push_back('{1'b1, 32'(e), tag});
    #4;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic pulse(input logic [3:0] rt, input logic ex);
    @(negedge clk);
    rate_tick = rt; ext_tick = ex;
    @(negedge clk);
    rate_tick = '0; ext_tick = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_rd(8'h04, 0, "R1 count0");
    expect_rd(8'h14, 0, "R1 count1");
    expect_rd(8'h48, 0, "R1 mask");
    expect_rd(8'h50, 0, "R1 raw");
    expect_irq(0, "R1 irq");

    wr(8'h00, 3);
    expect_rd(8'h00, 3, "R2 reload0 readback");
    expect_rd(8'h20, 0, "R2 unmapped read");
    wr(8'h04, 55);
    wr(8'h20, 77);
    expect_rd(8'h04, 0, "R2 count write ignored");

    wr(8'h08, (4 << 2) | 0);
    expect_rd(8'h04, 3, "R3 load copies reload");
    pulse(4'b0001, 0);
    expect_rd(8'h04, 3, "R3 stays stopped after load");

    wr(8'h08, (4 << 2) | 2);
    pulse(4'b0010, 0);
    expect_rd(8'h04, 3, "R6 unselected rate ignored");
    pulse(4'b0000, 1);
    expect_rd(8'h04, 3, "R6 ext ignored for code 4");
    pulse(4'b0001, 0);
    expect_rd(8'h04, 2, "R4 run decrements");
    pulse(4'b0001, 0);
    expect_rd(8'h04, 1, "R4 run decrements again");
    expect_rd(8'h50, 0, "R5 no expiry yet");
    pulse(4'b0001, 0);
    expect_rd(8'h04, 3, "R5 reload on expiry");
    expect_rd(8'h50, 1, "R5 channel 0 sets bit 0");
    expect_irq(0, "R7 irq low while masked");
    expect_rd(8'h54, 0, "R7 masked status zero");

    wr(8'h48, 1);
    expect_rd(8'h48, 1, "R9 mask readback");
    expect_irq(1, "R7 irq high when unmasked");
    expect_rd(8'h54, 1, "R7 masked status");

    wr(8'h08, (4 << 2) | 1);
    pulse(4'b0001, 0);
    expect_rd(8'h04, 3, "R4 hold freezes");
    wr(8'h08, (4 << 2) | 3);
    pulse(4'b0001, 0);
    expect_rd(8'h04, 3, "R4 code 3 freezes");

    wr(8'h10, 2);
    wr(8'h18, 0);
    expect_rd(8'h14, 2, "R3 channel 1 load");
    wr(8'h18, (1 << 2) | 2);
    pulse(4'b0000, 1);
    expect_rd(8'h14, 1, "R6 ext tick for code 1");
    pulse(4'b0000, 1);
    expect_rd(8'h14, 2, "R5 channel 1 reload");
    expect_rd(8'h50, 3, "R5 channel 1 sets bit 1");
    expect_rd(8'h54, 1, "R7 masked status with bit 1 masked");
    wr(8'h50, 0);
    wr(8'h54, 0);
    expect_rd(8'h50, 3, "R2 status write ignored");

    wr(8'h18, (2 << 2) | 2);
    pulse(4'b1111, 1);
    expect_rd(8'h14, 2, "R6 code 2 has no tick");
    wr(8'h18, (7 << 2) | 2);
    pulse(4'b0111, 1);
    expect_rd(8'h14, 2, "R6 code 7 ignores others");
    pulse(4'b1000, 0);
    expect_rd(8'h14, 1, "R6 code 7 uses rate 3");

    wr(8'h4C, 2);
    expect_rd(8'h50, 1, "R8 ack clears only bit 1");
    wr(8'h4C, 1);
    expect_rd(8'h50, 0, "R8 ack clears bit 0");
    expect_irq(0, "R8 irq low after ack");

    @(negedge clk);
    wr_en = 1'b1; addr = 8'h4C; wdata = 2; rate_tick = 4'b1000;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; rate_tick = '0;
    expect_rd(8'h50, 2, "R8 set wins over ack");
    expect_rd(8'h14, 2, "R5 reload at collision");

    wr(8'h48, 2);
    expect_irq(1, "R9 new mask drives irq");
    expect_rd(8'h50, 2, "R9 raw unchanged by mask write");
    wr(8'h48, 0);
    expect_irq(0, "R9 mask cleared");

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule